// File: doc/BRIEF.md
# MAC User-Side Stream Adapter

This block sits between user logic and a bufferless 10G Ethernet MAC. It turns the MAC's rigid streaming rules into ordinary AXI4-Stream behaviour. Both sides are 64-bit AXI4-Stream with a byte keep mask and an end-of-frame flag.

In the receive direction the MAC pushes beats every cycle it has them and cannot be stalled. The adapter writes each frame into a store. It makes the frame visible to the user only once the last beat has arrived with a good check indication. A frame flagged bad is discarded by moving the write pointer back to the frame start. A frame that meets a full store is discarded whole. The user may then hold off the stream with `urx_ready` for as long as it likes.

In the transmit direction the user may leave idle cycles between beats. The adapter stores each frame and offers it to the MAC only after its last beat is held. Once started, the frame goes out on consecutive cycles, so the MAC never sees an underrun. The price of both directions is added latency: a whole frame is held before any of it is forwarded.

Receive ingest states: `RI_IDLE` (between frames), `RI_STORE` (inside a frame being kept), `RI_DROP` (inside a frame being discarded). Transitions:
- `RI_IDLE` or `RI_STORE` to `RI_STORE` on a non-last beat with room.
- Either of them to `RI_DROP` on a non-last beat that finds the store full.
- Either of them to `RI_IDLE` on any last beat.
- `RI_DROP` to `RI_IDLE` on the last beat.

Transmit launch states: `TL_WAIT` (no frame in flight) and `TL_BURST` (frame in flight). The block moves from `TL_WAIT` to `TL_BURST` when a non-last first beat is accepted by the MAC. It moves from `TL_BURST` back to `TL_WAIT` when the last beat is accepted.

Top module: `mac_user_shim`

## Requirements
- R1: During and right after reset, `urx_valid` and `mtx_valid` are low and `utx_ready` is high.
- R2: Receive frames whose last beat has `mrx_bad` low reach the user complete, in arrival order, with data, keep and last unchanged.
- R3: A receive frame whose last beat carries `mrx_bad` high never appears at the user port. `mrx_bad` on non-last beats has no effect.
- R4: While `urx_valid` is high and `urx_ready` is low, the offered receive beat stays unchanged on the next cycle.
- R5: A receive beat arriving when DEPTH beats are held, counting the current frame's own beats, causes the whole frame to be dropped. No part of it ever reaches the user.
- R6: A good receive frame becomes visible on `urx_valid` in the cycle after its last beat enters, and not before.
- R7: `utx_ready` is low exactly when DEPTH transmit beats are held (stored but not yet accepted by the MAC).
- R8: A transmit frame is offered to the MAC (`mtx_valid` high) from the cycle after its last beat is accepted from the user, and no earlier. Frames leave in the order received, intact.
- R9: After the MAC accepts a non-last transmit beat, `mtx_valid` is high in every following cycle until the last beat is accepted.
- R10: While `mtx_valid` is high and `mtx_ready` is low, the offered transmit beat stays unchanged on the next cycle.
- R11: `mtx_user`, the underrun flag toward the MAC, is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrx_data | input | 64 | Receive data from the MAC |
| mrx_keep | input | 8 | Receive byte enables from the MAC |
| mrx_valid | input | 1 | Receive beat present (cannot be stalled) |
| mrx_last | input | 1 | Last beat of a receive frame |
| mrx_bad | input | 1 | With the last beat: the frame failed its check |
| urx_data | output | 64 | Receive data to the user |
| urx_keep | output | 8 | Receive byte enables to the user |
| urx_valid | output | 1 | Receive beat offered to the user |
| urx_last | output | 1 | Last beat of the offered frame |
| urx_ready | input | 1 | User accepts the receive beat |
| utx_data | input | 64 | Transmit data from the user |
| utx_keep | input | 8 | Transmit byte enables from the user |
| utx_valid | input | 1 | Transmit beat offered by the user |
| utx_last | input | 1 | Last beat of a transmit frame |
| utx_ready | output | 1 | Adapter accepts the transmit beat |
| mtx_data | output | 64 | Transmit data to the MAC |
| mtx_keep | output | 8 | Transmit byte enables to the MAC |
| mtx_valid | output | 1 | Transmit beat offered to the MAC |
| mtx_last | output | 1 | Last beat of the transmit frame |
| mtx_user | output | 1 | Underrun flag to the MAC, held low |
| mtx_ready | input | 1 | MAC accepts the transmit beat |

## Verification
Receive traffic first runs with the user always ready and a mix of good and bad frames, including one-beat frames. This separates correct discard from loss or reordering of good frames. A long stall of `urx_ready` while frames keep arriving then fills the store. This shows whether a frame meeting a full store is dropped whole or leaks a partial tail. A phase of random user stalls checks that held beats stay stable. On transmit, beats with random idle gaps separate gating on the last beat from early release. MAC-side stalls, and a phase with the MAC blocked until the store fills, probe burst continuity and the exact point at which `utx_ready` falls.

// File: rtl/shim_pkg.sv
`timescale 1ns/1ps
package shim_pkg;
    parameter int BEAT_BYTES = 8;
    localparam int BEAT_BITS = BEAT_BYTES * 8;

    typedef struct packed {
        logic [BEAT_BITS-1:0]  data;
        logic [BEAT_BYTES-1:0] keep;
        logic                  last;
    } beat_t;

    typedef enum logic [1:0] {
        RI_IDLE  = 2'd0,
        RI_STORE = 2'd1,
        RI_DROP  = 2'd2
    } ingest_state_e;

    typedef enum logic {
        TL_WAIT  = 1'b0,
        TL_BURST = 1'b1
    } launch_state_e;
endpackage

// File: rtl/frame_store.sv
`timescale 1ns/1ps
// Beat store with a speculative write pointer and a committed pointer.
// The read side only sees beats below the committed pointer.
// DEPTH must be a power of two.
module frame_store
    import shim_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  beat_t wr_beat,
    input  logic  commit,
    input  logic  rollback,
    output logic  full,
    input  logic  rd_en,
    output beat_t rd_beat,
    output logic  rd_avail
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
    beat_t         mem [DEPTH];

    assign full     = (wr_ptr - rd_ptr) == PW'(DEPTH);
    assign rd_avail = (rd_ptr != cm_ptr);
    assign rd_beat  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en && !rollback) begin
            mem[wr_ptr[AW-1:0]] <= wr_beat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (rollback) begin
                wr_ptr <= cm_ptr;
            end else if (wr_en) begin
                wr_ptr <= wr_ptr + PW'(1);
            end
            if (commit) begin
                cm_ptr <= wr_ptr + PW'(1);
            end
            if (rd_en) begin
                rd_ptr <= rd_ptr + PW'(1);
            end
        end
    end

    // R5 R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

    // R2 R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_avail);

    // R3
    commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!rollback && wr_en));
endmodule

// File: rtl/rx_ingest.sv
`timescale 1ns/1ps
// Receive ingest control: keeps good frames, discards bad or oversize ones.
module rx_ingest
    import shim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    input  logic in_bad,
    input  logic full,
    output logic wr_en,
    output logic commit,
    output logic rollback
);
    ingest_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RI_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        wr_en    = 1'b0;
        commit   = 1'b0;
        rollback = 1'b0;
        unique case (state_q)
            RI_IDLE, RI_STORE: begin
                if (in_valid) begin
                    if (full) begin
                        rollback = (state_q == RI_STORE);
                        state_d  = in_last ? RI_IDLE : RI_DROP;
                    end else if (in_last) begin
                        state_d = RI_IDLE;
                        if (in_bad) begin
                            rollback = 1'b1;
                        end else begin
                            wr_en  = 1'b1;
                            commit = 1'b1;
                        end
                    end else begin
                        wr_en   = 1'b1;
                        state_d = RI_STORE;
                    end
                end
            end
            RI_DROP: begin
                if (in_valid && in_last) begin
                    state_d = RI_IDLE;
                end
            end
            default: state_d = RI_IDLE;
        endcase
    end

    // R5
    drop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RI_DROP && in_valid && in_last) |=> (state_q == RI_IDLE));
endmodule

// File: rtl/tx_launch.sv
`timescale 1ns/1ps
// Transmit launch control: starts a frame only when committed, then bursts it.
module tx_launch
    import shim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic avail,
    input  logic head_last,
    input  logic mac_ready,
    output logic mac_valid,
    output logic pop
);
    launch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TL_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        mac_valid = 1'b0;
        pop       = 1'b0;
        unique case (state_q)
            TL_WAIT: begin
                mac_valid = avail;
                pop       = avail && mac_ready;
                if (pop && !head_last) begin
                    state_d = TL_BURST;
                end
            end
            TL_BURST: begin
                mac_valid = 1'b1;
                pop       = mac_ready;
                if (mac_ready && head_last) begin
                    state_d = TL_WAIT;
                end
            end
            default: state_d = TL_WAIT;
        endcase
    end

    // R9
    burst_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TL_BURST) |-> avail);

    // R10
    launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && !mac_ready) |=> mac_valid);
endmodule

// File: rtl/mac_user_shim.sv
`timescale 1ns/1ps
module mac_user_shim
    import shim_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BEAT_BITS-1:0]  mrx_data,
    input  logic [BEAT_BYTES-1:0] mrx_keep,
    input  logic                  mrx_valid,
    input  logic                  mrx_last,
    input  logic                  mrx_bad,
    output logic [BEAT_BITS-1:0]  urx_data,
    output logic [BEAT_BYTES-1:0] urx_keep,
    output logic                  urx_valid,
    output logic                  urx_last,
    input  logic                  urx_ready,
    input  logic [BEAT_BITS-1:0]  utx_data,
    input  logic [BEAT_BYTES-1:0] utx_keep,
    input  logic                  utx_valid,
    input  logic                  utx_last,
    output logic                  utx_ready,
    output logic [BEAT_BITS-1:0]  mtx_data,
    output logic [BEAT_BYTES-1:0] mtx_keep,
    output logic                  mtx_valid,
    output logic                  mtx_last,
    output logic                  mtx_user,
    input  logic                  mtx_ready
);
    // ---------------- receive direction ----------------
    logic  rx_wr, rx_commit, rx_rollback, rx_full, rx_pop, rx_avail;
    beat_t rx_in, rx_head;

    assign rx_in = '{data: mrx_data, keep: mrx_keep, last: mrx_last};

    rx_ingest rx_ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (mrx_valid),
        .in_last  (mrx_last),
        .in_bad   (mrx_bad),
        .full     (rx_full),
        .wr_en    (rx_wr),
        .commit   (rx_commit),
        .rollback (rx_rollback)
    );

    frame_store #(.DEPTH(DEPTH)) rx_store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rx_wr),
        .wr_beat  (rx_in),
        .commit   (rx_commit),
        .rollback (rx_rollback),
        .full     (rx_full),
        .rd_en    (rx_pop),
        .rd_beat  (rx_head),
        .rd_avail (rx_avail)
    );

    assign urx_valid = rx_avail;
    assign urx_data  = rx_head.data;
    assign urx_keep  = rx_head.keep;
    assign urx_last  = rx_head.last;
    assign rx_pop    = rx_avail && urx_ready;

    // ---------------- transmit direction ----------------
    logic  tx_wr, tx_commit, tx_full, tx_pop, tx_avail;
    beat_t tx_in, tx_head;

    assign tx_in     = '{data: utx_data, keep: utx_keep, last: utx_last};
    assign utx_ready = !tx_full;
    assign tx_wr     = utx_valid && !tx_full;
    assign tx_commit = tx_wr && utx_last;

    frame_store #(.DEPTH(DEPTH)) tx_store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tx_wr),
        .wr_beat  (tx_in),
        .commit   (tx_commit),
        .rollback (1'b0),
        .full     (tx_full),
        .rd_en    (tx_pop),
        .rd_beat  (tx_head),
        .rd_avail (tx_avail)
    );

    tx_launch tx_ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .avail     (tx_avail),
        .head_last (tx_head.last),
        .mac_ready (mtx_ready),
        .mac_valid (mtx_valid),
        .pop       (tx_pop)
    );

    assign mtx_data = tx_head.data;
    assign mtx_keep = tx_head.keep;
    assign mtx_last = tx_head.last;
    assign mtx_user = 1'b0;

    // R4
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urx_valid && !urx_ready) |=>
            (urx_valid && $stable(urx_data) && $stable(urx_keep) && $stable(urx_last)));

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mtx_valid && !mtx_ready) |=>
            (mtx_valid && $stable(mtx_data) && $stable(mtx_keep) && $stable(mtx_last)));
endmodule

// File: tb/mac_user_shim_tb.sv
`timescale 1ns/1ps
module mac_user_shim_tb_top;
    localparam int DEPTH = 16;

    typedef struct packed {
        logic [63:0] d;
        logic [7:0]  k;
        logic        l;
    } bt_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] mrx_data = '0;
    logic [7:0]  mrx_keep = '0;
    logic        mrx_valid = 1'b0, mrx_last = 1'b0, mrx_bad = 1'b0;
    logic [63:0] urx_data;
    logic [7:0]  urx_keep;
    logic        urx_valid, urx_last;
    logic        urx_ready = 1'b1;
    logic [63:0] utx_data = '0;
    logic [7:0]  utx_keep = '0;
    logic        utx_valid = 1'b0, utx_last = 1'b0;
    logic        utx_ready;
    logic [63:0] mtx_data;
    logic [7:0]  mtx_keep;
    logic        mtx_valid, mtx_last, mtx_user;
    logic        mtx_ready = 1'b1;

    int total = 0, fails = 0;
    bit done = 1'b0;
    int rx_phase = 0, tx_phase = 0;
    int rx_full_drops = 0, rx_bad_frames = 0;

    always #2.5 clk = ~clk;

    mac_user_shim #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mrx_data(mrx_data), .mrx_keep(mrx_keep), .mrx_valid(mrx_valid),
        .mrx_last(mrx_last), .mrx_bad(mrx_bad),
        .urx_data(urx_data), .urx_keep(urx_keep), .urx_valid(urx_valid),
        .urx_last(urx_last), .urx_ready(urx_ready),
        .utx_data(utx_data), .utx_keep(utx_keep), .utx_valid(utx_valid),
        .utx_last(utx_last), .utx_ready(utx_ready),
        .mtx_data(mtx_data), .mtx_keep(mtx_keep), .mtx_valid(mtx_valid),
        .mtx_last(mtx_last), .mtx_user(mtx_user), .mtx_ready(mtx_ready)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] keep_of(input int nbytes);
        return 8'((16'h1 << nbytes) - 1);
    endfunction

    // ---------------- reference model, evaluated every negedge ----------------
    bt_t rx_vis[$], rx_pend[$], tx_vis[$], tx_pend[$];
    bit  rx_drop = 1'b0, rx_prev_stall = 1'b0, tx_prev_stall = 1'b0, tx_inframe = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit  full_now;
            bt_t got;
            // receive outputs
            chk(urx_valid === (rx_vis.size() > 0), "R6 urx_valid", 64'(urx_valid), 64'(rx_vis.size() > 0));
            if (urx_valid === 1'b1 && rx_vis.size() > 0) begin
                got = '{d: urx_data, k: urx_keep, l: urx_last};
                chk(got.d === rx_vis[0].d, rx_prev_stall ? "R4 urx_data" : "R2 urx_data", got.d, rx_vis[0].d);
                chk({got.k, got.l} === {rx_vis[0].k, rx_vis[0].l}, "R2 urx_keep_last",
                    64'({got.k, got.l}), 64'({rx_vis[0].k, rx_vis[0].l}));
            end
            full_now = (rx_vis.size() + rx_pend.size()) >= DEPTH;
            rx_prev_stall = urx_valid && !urx_ready;
            if (urx_valid && urx_ready && rx_vis.size() > 0) void'(rx_vis.pop_front());
            if (mrx_valid) begin
                if (rx_drop) begin
                    if (mrx_last) rx_drop = 1'b0;
                end else if (full_now) begin
                    rx_pend.delete();
                    rx_full_drops++;
                    rx_drop = !mrx_last;
                end else if (mrx_last && mrx_bad) begin
                    rx_pend.delete();
                    rx_bad_frames++;
                end else begin
                    rx_pend.push_back('{d: mrx_data, k: mrx_keep, l: mrx_last});
                    if (mrx_last) begin
                        foreach (rx_pend[i]) rx_vis.push_back(rx_pend[i]);
                        rx_pend.delete();
                    end
                end
            end
            // transmit outputs
            chk(utx_ready === ((tx_vis.size() + tx_pend.size()) < DEPTH), "R7 utx_ready",
                64'(utx_ready), 64'((tx_vis.size() + tx_pend.size()) < DEPTH));
            chk(mtx_valid === (tx_vis.size() > 0), tx_inframe ? "R9 mtx_valid" : "R8 mtx_valid",
                64'(mtx_valid), 64'(tx_vis.size() > 0));
            chk(mtx_user === 1'b0, "R11 mtx_user", 64'(mtx_user), 64'd0);
            if (mtx_valid === 1'b1 && tx_vis.size() > 0) begin
                got = '{d: mtx_data, k: mtx_keep, l: mtx_last};
                chk(got.d === tx_vis[0].d, tx_prev_stall ? "R10 mtx_data" : "R8 mtx_data", got.d, tx_vis[0].d);
                chk({got.k, got.l} === {tx_vis[0].k, tx_vis[0].l}, "R8 mtx_keep_last",
                    64'({got.k, got.l}), 64'({tx_vis[0].k, tx_vis[0].l}));
            end
            tx_prev_stall = mtx_valid && !mtx_ready;
            if (mtx_valid && mtx_ready && tx_vis.size() > 0) begin
                tx_inframe = !tx_vis[0].l;
                void'(tx_vis.pop_front());
            end
            if (utx_valid && utx_ready) begin
                tx_pend.push_back('{d: utx_data, k: utx_keep, l: utx_last});
                if (utx_last) begin
                    foreach (tx_pend[i]) tx_vis.push_back(tx_pend[i]);
                    tx_pend.delete();
                end
            end
        end
    end

    // ---------------- ready generators ----------------
    initial begin
        forever begin
            @(posedge clk); #1;
            case (rx_phase)
                1:       urx_ready = 1'b0;
                2:       urx_ready = 1'($urandom % 2);
                default: urx_ready = 1'b1;
            endcase
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            case (tx_phase)
                1:       mtx_ready = ($urandom % 4) != 0;
                2:       mtx_ready = 1'b0;
                default: mtx_ready = 1'b1;
            endcase
        end
    end

    // ---------------- stimulus tasks (start and end at posedge+1) ----------------
    task automatic send_rx(input int fid, input int len, input bit bad, input int gap);
        for (int i = 0; i < len; i++) begin
            mrx_valid = 1'b1;
            mrx_data  = {16'(fid), 16'(i), 32'($urandom)};
            mrx_last  = (i == len - 1);
            mrx_keep  = mrx_last ? keep_of(1 + int'($urandom % 8)) : 8'hFF;
            mrx_bad   = mrx_last ? bad : 1'($urandom % 2); // R3: ignored off the last beat
            @(posedge clk); #1;
        end
        mrx_valid = 1'b0; mrx_last = 1'b0; mrx_bad = 1'b0;
        repeat (gap) begin @(posedge clk); #1; end
    endtask

    task automatic send_tx(input int fid, input int len, input int maxgap);
        for (int i = 0; i < len; i++) begin
            int g;
            g = (maxgap > 0) ? int'($urandom % (maxgap + 1)) : 0;
            utx_valid = 1'b0;
            repeat (g) begin @(posedge clk); #1; end
            utx_valid = 1'b1;
            utx_data  = {16'(fid), 16'(i), 32'($urandom)};
            utx_last  = (i == len - 1);
            utx_keep  = utx_last ? keep_of(1 + int'($urandom % 8)) : 8'hFF;
            @(negedge clk);
            while (!utx_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        utx_valid = 1'b0; utx_last = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(29));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(urx_valid === 1'b0, "R1 urx_valid", 64'(urx_valid), 64'd0);
        chk(mtx_valid === 1'b0, "R1 mtx_valid", 64'(mtx_valid), 64'd0);
        chk(utx_ready === 1'b1, "R1 utx_ready", 64'(utx_ready), 64'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(urx_valid === 1'b0 && mtx_valid === 1'b0, "R1 after release",
            64'({urx_valid, mtx_valid}), 64'd0);
        @(posedge clk); #1;
        fork
            begin : rx_seq
                rx_phase = 0;
                for (int f = 0; f < 24; f++)
                    send_rx(16'h100 + f, 1 + int'($urandom % 10), (f % 5) == 2, int'($urandom % 3));
                rx_phase = 1;   // user blocked: store fills, frames dropped (R5)
                for (int f = 0; f < 8; f++)
                    send_rx(16'h200 + f, 4 + int'($urandom % 3), 1'b0, 0);
                rx_phase = 2;
                for (int f = 0; f < 24; f++)
                    send_rx(16'h300 + f, 1 + int'($urandom % 8), (f % 7) == 3, int'($urandom % 2));
                rx_phase = 0;
            end
            begin : tx_seq
                tx_phase = 0;
                for (int f = 0; f < 20; f++) send_tx(16'h500 + f, 1 + int'($urandom % 10), 2);
                tx_phase = 1;
                for (int f = 0; f < 20; f++) send_tx(16'h600 + f, 1 + int'($urandom % 10), 1);
                repeat (60) begin @(posedge clk); #1; end
                tx_phase = 2;   // MAC blocked: exactly DEPTH beats fill the store (R7)
                send_tx(16'h700, DEPTH / 2, 0);
                send_tx(16'h701, DEPTH / 2, 0);
                repeat (6) begin @(posedge clk); #1; end
                tx_phase = 0;
                for (int f = 0; f < 10; f++) send_tx(16'h800 + f, 1 + int'($urandom % 6), 0);
            end
        join
        repeat (120) begin @(posedge clk); #1; end
        @(negedge clk);
        chk(rx_vis.size() == 0 && rx_pend.size() == 0, "R2 rx drained", 64'(rx_vis.size()), 64'd0);
        chk(tx_vis.size() == 0 && tx_pend.size() == 0, "R8 tx drained", 64'(tx_vis.size()), 64'd0);
        chk(rx_full_drops > 0, "R5 full drop exercised", 64'(rx_full_drops), 64'd1);
        chk(rx_bad_frames > 0, "R3 bad frame exercised", 64'(rx_bad_frames), 64'd1);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule